// File: doc/BRIEF.md
# Cache Transaction Register Bank

This block is a slave register file on an I/O-side bus. Through it, an I/O processor can drive single transactions into a cache's processor-side port, the same way a regular processor does. Software first loads an address register and a data register. It then writes a command register. That write starts exactly one cache transaction. The I/O bus write is held, with ready low, until the cache reports either completion or a fault.

The data register is byte-reversed against the system bus, so full 32-bit words keep their value on both sides. A read command stores the cache's returned word into the data register. When a transaction faults, the bank latches three things from the failing request: the address, the bus-order data and the command. It also sets a fault flag and raises an interrupt. The interrupt stays up until software writes any value to the fault register. The cache is modelled by a plain request/done/fault handshake.

Register indices on `host_idx`:

| Index | Register |
|-------|----------|
| 0 | data |
| 1 | address |
| 2 | command |
| 3 | fault |
| 4 | error-data |
| 5 | error-address |
| 6 | error-command |

Top module: `xact_regbank`

## Requirements
- R1: While reset is asserted, and right after it, `cache_req` and `irq` are low and every register (indices 0 to 6) reads zero.
- R2: The data (index 0) and address (index 1) registers read back what was last written. Reads, and writes to any index other than 2, complete with `host_ready` high in the same cycle.
- R3: During a transaction, `cache_addr` equals the address register and `cache_wdata` equals the data register with its bytes reversed (register bits 7:0 on bus bits 31:24, and so on). `cache_cmd` equals the written command, where command bit 0 set to 1 means read and 0 means write. All three stay stable while the request is pending.
- R4: A write to index 2 raises `cache_req` for exactly one transaction. The request is held until `cache_done` or `cache_fault`, and `host_ready` stays low until that response. With a response L cycles after the request appears, the host write completes on the (L+2)-th edge.
- R5: A read command that completes without fault loads the data register with `cache_rdata` byte-reversed.
- R6: Index 2 reads the last command that completed without fault. A faulting command leaves it unchanged.
- R7: A fault sets bit 0 of the fault register (index 3). All other bits read zero, and `irq` is high exactly while the bit is set.
- R8: On a fault, index 4 captures `cache_wdata`, index 5 captures `cache_addr` and index 6 captures `cache_cmd`, all from the failing request. The capture happens for read commands as well.
- R9: A write of any value to index 3 clears the fault bit and drops `irq`. Writes to indices 4 to 6 are ignored.
- R10: A read command that faults leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | Host access strobe, held until ready is seen |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_idx | input | 3 | Register index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| host_ready | output | 1 | Access completes on the edge where this is high |
| cache_req | output | 1 | Transaction request to the cache |
| cache_cmd | output | 8 | Command of the pending transaction |
| cache_addr | output | 32 | Transaction address |
| cache_wdata | output | 32 | Transaction data in bus byte order |
| cache_rdata | input | 32 | Data returned by the cache |
| cache_done | input | 1 | Transaction completed |
| cache_fault | input | 1 | Transaction faulted (ends it) |
| irq | output | 1 | Fault interrupt |

## Verification
Register reads are combinational, so the bench samples `host_rdata` a short delay after it drives the access, away from any edge. A command write has `cache_req` up one edge after the access begins. The bench's cache model answers a programmable number of cycles later, and the bench counts the ready-low samples: it expects exactly latency plus one. The data, last-command, fault and error registers update on the edge that ends the host write, so the bench reads them only in later accesses. This is repeated for latencies 0 to 4 across read, write and faulting commands.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
  typedef enum logic [2:0] {
    RI_DATA  = 3'd0,
    RI_ADDR  = 3'd1,
    RI_CMD   = 3'd2,
    RI_FAULT = 3'd3,
    RI_EDATA = 3'd4,
    RI_EADDR = 3'd5,
    RI_ECMD  = 3'd6
  } reg_idx_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/xreg_swap.sv
module xreg_swap #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NB = W / 8;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign dout[8*g +: 8] = din[8*(NB-1-g) +: 8];
  end
endmodule

// File: rtl/xreg_seq.sv
module xreg_seq
  import xreg_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cmd_in,
  input  logic          done,
  input  logic          fault,
  output logic          busy,
  output logic [CW-1:0] pend_cmd,
  output logic          fin_ok,
  output logic          fin_err
);
  seq_state_e    state_q, state_d;
  logic [CW-1:0] cmd_q, cmd_d;
  logic          cmd_en;

  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_q;
    cmd_en  = 1'b0;
    unique case (state_q)
      SQ_IDLE: if (start) begin
        state_d = SQ_BUSY;
        cmd_d   = cmd_in;
        cmd_en  = 1'b1;
      end
      SQ_BUSY: if (done || fault) state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cmd_en) cmd_q <= cmd_d;
    end
  end

  assign busy     = (state_q == SQ_BUSY);
  assign pend_cmd = cmd_q;
  assign fin_err  = busy && fault;
  assign fin_ok   = busy && done && !fault;
endmodule

// File: rtl/xreg_fault.sv
module xreg_fault #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic          clr,
  input  logic [DW-1:0] cap_data,
  input  logic [DW-1:0] cap_addr,
  input  logic [CW-1:0] cap_cmd,
  output logic          flag,
  output logic [DW-1:0] err_data,
  output logic [DW-1:0] err_addr,
  output logic [CW-1:0] err_cmd
);
  logic flag_q, flag_d;
  logic [DW-1:0] edata_q, eaddr_q;
  logic [CW-1:0] ecmd_q;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      edata_q <= '0;
      eaddr_q <= '0;
      ecmd_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (set) begin
        edata_q <= cap_data;
        eaddr_q <= cap_addr;
        ecmd_q  <= cap_cmd;
      end
    end
  end

  assign flag     = flag_q;
  assign err_data = edata_q;
  assign err_addr = eaddr_q;
  assign err_cmd  = ecmd_q;
endmodule

// File: rtl/xact_regbank.sv
module xact_regbank
  import xreg_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CW    = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sel,
  input  logic             host_wr,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  output logic             host_ready,
  output logic             cache_req,
  output logic [CW-1:0]    cache_cmd,
  output logic [DW-1:0]    cache_addr,
  output logic [DW-1:0]    cache_wdata,
  input  logic [DW-1:0]    cache_rdata,
  input  logic             cache_done,
  input  logic             cache_fault,
  output logic             irq
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_q = rst_sync_q[SYNC_N-1];

  logic [DW-1:0] data_q, data_d, addr_q, addr_d;
  logic [CW-1:0] last_q, last_d;
  logic          data_en, addr_en, last_en;
  logic [DW-1:0] rd_swapped;
  logic          busy, fin_ok, fin_err, start;
  logic [CW-1:0] pend_cmd;
  logic          fault_flag, fault_clr;
  logic [DW-1:0] err_data_q, err_addr_q;
  logic [CW-1:0] err_cmd_q;
  logic          wr_cmd, wr_acc;

  assign wr_cmd     = host_sel && host_wr && (host_idx == RI_CMD);
  assign host_ready = !wr_cmd || fin_ok || fin_err;
  assign wr_acc     = host_sel && host_wr && host_ready;
  assign start      = wr_cmd && !busy;
  assign fault_clr  = wr_acc && (host_idx == RI_FAULT);

  xreg_swap #(.W(DW)) u_tx_swap (.din(data_q),      .dout(cache_wdata));
  xreg_swap #(.W(DW)) u_rx_swap (.din(cache_rdata), .dout(rd_swapped));

  xreg_seq #(.CW(CW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_q),
    .start   (start),
    .cmd_in  (host_wdata[CW-1:0]),
    .done    (cache_done),
    .fault   (cache_fault),
    .busy    (busy),
    .pend_cmd(pend_cmd),
    .fin_ok  (fin_ok),
    .fin_err (fin_err)
  );

  xreg_fault #(.DW(DW), .CW(CW)) u_fault (
    .clk     (clk),
    .rst_n   (rst_q),
    .set     (fin_err),
    .clr     (fault_clr),
    .cap_data(cache_wdata),
    .cap_addr(addr_q),
    .cap_cmd (pend_cmd),
    .flag    (fault_flag),
    .err_data(err_data_q),
    .err_addr(err_addr_q),
    .err_cmd (err_cmd_q)
  );

  always_comb begin
    data_d  = data_q;
    data_en = 1'b0;
    addr_d  = addr_q;
    addr_en = 1'b0;
    last_d  = last_q;
    last_en = 1'b0;
    if (wr_acc && host_idx == RI_DATA) begin
      data_d  = host_wdata;
      data_en = 1'b1;
    end
    if (wr_acc && host_idx == RI_ADDR) begin
      addr_d  = host_wdata;
      addr_en = 1'b1;
    end
    if (fin_ok) begin
      last_d  = pend_cmd;
      last_en = 1'b1;
      if (pend_cmd[0]) begin
        data_d  = rd_swapped;
        data_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      data_q <= '0;
      addr_q <= '0;
      last_q <= '0;
    end else begin
      if (data_en) data_q <= data_d;
      if (addr_en) addr_q <= addr_d;
      if (last_en) last_q <= last_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    unique case (host_idx)
      RI_DATA:  host_rdata = data_q;
      RI_ADDR:  host_rdata = addr_q;
      RI_CMD:   host_rdata[CW-1:0] = last_q;
      RI_FAULT: host_rdata[0] = fault_flag;
      RI_EDATA: host_rdata = err_data_q;
      RI_EADDR: host_rdata = err_addr_q;
      RI_ECMD:  host_rdata[CW-1:0] = err_cmd_q;
      default:  host_rdata = '0;
    endcase
  end

  assign cache_req  = busy;
  assign cache_cmd  = pend_cmd;
  assign cache_addr = addr_q;
  assign irq        = fault_flag;
endmodule

// File: rtl/xreg_chk.sv
module xreg_chk #(
  parameter int DW    = 32,
  parameter int CW    = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_sel,
  input logic             host_wr,
  input logic [IDX_W-1:0] host_idx,
  input logic             host_ready,
  input logic             cache_req,
  input logic             cache_done,
  input logic             cache_fault,
  input logic [CW-1:0]    cache_cmd,
  input logic [DW-1:0]    cache_addr,
  input logic             irq,
  input logic [DW-1:0]    err_addr
);
  logic pending, cmd_wr, fault_wr;
  assign pending  = cache_req && !cache_done && !cache_fault;
  assign cmd_wr   = host_sel && host_wr && (host_idx == 3'd2);
  assign fault_wr = host_sel && host_wr && (host_idx == 3'd3);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!cache_req && !irq));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> cache_req);

  p_fields_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> ($stable(cache_cmd) && $stable(cache_addr)));

  p_ready_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && host_ready) |-> (cache_req && (cache_done || cache_fault)));

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cache_req && cache_fault));

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !fault_wr) |=> irq);

  p_err_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_req && cache_fault) |=> (err_addr == $past(cache_addr)));
endmodule

bind xact_regbank xreg_chk #(.DW(DW), .CW(CW), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_sel   (host_sel),
  .host_wr    (host_wr),
  .host_idx   (host_idx),
  .host_ready (host_ready),
  .cache_req  (cache_req),
  .cache_done (cache_done),
  .cache_fault(cache_fault),
  .cache_cmd  (cache_cmd),
  .cache_addr (cache_addr),
  .irq        (irq),
  .err_addr   (err_addr_q)
);

// File: tb/sim_xact_regbank.sv
`timescale 1ns/1ps
module sim_xact_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0;
  logic [2:0]  host_idx = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        host_ready, cache_req, irq;
  logic [7:0]  cache_cmd;
  logic [31:0] cache_addr, cache_wdata;
  logic [31:0] cache_rdata = '0;
  logic        cache_done = 1'b0, cache_fault = 1'b0;

  int checks = 0, errors = 0;
  int lat = 0, cnt = 0, n_resp = 0;
  logic        m_fault = 1'b0;
  logic [31:0] cap_addr, cap_wdata;
  logic [7:0]  cap_cmd;

  always #2.5 clk = ~clk;

  xact_regbank u0 (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready), .cache_req(cache_req), .cache_cmd(cache_cmd),
    .cache_addr(cache_addr), .cache_wdata(cache_wdata),
    .cache_rdata(cache_rdata), .cache_done(cache_done),
    .cache_fault(cache_fault), .irq(irq)
  );

  // cache model: answers lat cycles after the request appears
  always @(negedge clk) begin
    if (cache_done || cache_fault) begin
      cache_done  = 1'b0;
      cache_fault = 1'b0;
      cnt = 0;
    end else if (cache_req) begin
      if (cnt == lat) begin
        cap_addr  = cache_addr;
        cap_wdata = cache_wdata;
        cap_cmd   = cache_cmd;
        n_resp++;
        if (m_fault) cache_fault = 1'b1;
        else         cache_done  = 1'b1;
      end else cnt++;
    end
  end

  function automatic logic [31:0] rev(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] v);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_idx = idx;
    #1;
    v = host_rdata;
    check("R2 read ready", {31'b0, host_ready}, 32'd1);
    @(posedge clk); #1;
    host_sel = 1'b0;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d, output int waits);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_idx = idx; host_wdata = d;
    waits = 0;
    forever begin
      #2;
      if (host_ready) break;
      waits++;
      @(negedge clk);
    end
    @(posedge clk); #1;
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, d, a, rdv;
    logic [7:0]  c, last;
    int w, nb;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset req", {31'b0, cache_req}, 0);
    check("R1 reset irq", {31'b0, irq}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    for (int i = 0; i < 7; i++) begin
      rd(i[2:0], v);
      check("R1 reset reg", v, 0);
    end
    last = 8'h00;
    for (int L = 0; L < 5; L++) begin
      for (int k = 0; k < 6; k++) begin
        lat = L;
        d = 32'h11223344 + 32'h01010101 * k + 32'h10000000 * L;
        a = 32'h8000_0000 ^ (k * 32'h0000_1004) ^ (L << 20);
        c = {k[2:0], L[3:0], k[0]};
        m_fault = (k % 3 == 2);
        rdv = 32'hA1B2C3D4 ^ (k * 32'h00110011) ^ L;
        cache_rdata = rdv;
        wr(3'd0, d, w);
        check("R2 data write ready", w, 0);
        wr(3'd1, a, w);
        rd(3'd0, v); check("R2 data readback", v, d);
        rd(3'd1, v); check("R2 addr readback", v, a);
        nb = n_resp;
        wr(3'd2, {24'hFFFFFF, c}, w);
        check("R4 stall cycles", w, L + 1);
        check("R4 one request", n_resp, nb + 1);
        #1;
        check("R4 req dropped", {31'b0, cache_req}, 0);
        check("R3 bus addr", cap_addr, a);
        check("R3 bus data swapped", cap_wdata, rev(d));
        check("R3 bus cmd", {24'b0, cap_cmd}, {24'b0, c});
        if (m_fault) begin
          check("R7 irq set", {31'b0, irq}, 1);
          rd(3'd3, v); check("R7 fault reg", v, 1);
          rd(3'd4, v); check("R8 err data", v, rev(d));
          rd(3'd5, v); check("R8 err addr", v, a);
          rd(3'd6, v); check("R8 err cmd", v, {24'b0, c});
          rd(3'd2, v); check("R6 cmd unchanged on fault", v, {24'b0, last});
          rd(3'd0, v); check("R10 data kept on fault", v, d);
          wr(3'd4, 32'hDEADBEEF, w);
          wr(3'd5, 32'hDEADBEEF, w);
          wr(3'd6, 32'hEF, w);
          rd(3'd4, v); check("R9 err data write ignored", v, rev(d));
          rd(3'd5, v); check("R9 err addr write ignored", v, a);
          rd(3'd6, v); check("R9 err cmd write ignored", v, {24'b0, c});
          check("R9 irq held", {31'b0, irq}, 1);
          wr(3'd3, {24'b0, k[7:0]}, w);
          #1;
          check("R9 irq cleared", {31'b0, irq}, 0);
          rd(3'd3, v); check("R9 fault cleared", v, 0);
        end else begin
          last = c;
          rd(3'd2, v); check("R6 last cmd", v, {24'b0, c});
          rd(3'd0, v);
          if (c[0]) check("R5 read data swapped", v, rev(rdv));
          else      check("R5 write keeps data", v, d);
          check("R7 irq low", {31'b0, irq}, 0);
        end
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule